// File: doc/BRIEF.md
# Recursive Prefix Carry-Lookahead Adder

This block adds two unsigned (or two's-complement) N-bit operands and returns the N-bit sum, wrapping modulo 2^N. It is purely combinational: there is no clock, no register and no carry-in pin. Bit 0 always receives a carry of zero, and the carry out of the top bit is produced inside the tree but not brought out.

Carries are produced by a lookahead tree rather than a ripple chain. Each bit position first forms a generate/propagate pair. The bit range is then halved recursively: the lower half keeps ceil(n/2) positions and the upper half takes the rest. The lower half's group pair, together with the carry entering it, is evaluated to give the carry into the upper half. The two group pairs are also merged into one pair for the enclosing range. A range of one bit simply uses the carry handed to it. The sum bits are then formed from each operand bit pair and its own carry. The block is meant to sit inside a larger datapath wherever a fast, fixed-width wrap-around add is needed. Typical uses are the final stage of a multiplier or an address incrementer.

Top module: `prefix_adder`

## Requirements
- R1: For every pair of operands, sumOut equals (addendA + addendB) mod 2^WIDTH.
- R2: The carry out of the most significant bit is dropped. All ones plus 1 gives 0, and all ones plus all ones gives all ones with bit 0 cleared.
- R3: No carry enters bit 0. With both operands zero the sum is zero, and sumOut[0] is addendA[0] XOR addendB[0].
- R4: A carry created in the lowest bit travels through every position that propagates it. This holds across the boundary between the two halves of each split. For example, 0x7FFFFFFF + 1 = 0x80000000, and 0x0000FFFF + 1 = 0x00010000 at WIDTH 32.
- R5: The result of R1 holds for every WIDTH of 1 or more, including odd widths where the two halves of a split differ in size.
- R6: Swapping the two operands does not change sumOut.
- R7: When one operand is zero, sumOut equals the other operand.
- R8: sumOut follows a change of the operands within the same time step, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addendA | input | WIDTH | First operand |
| addendB | input | WIDTH | Second operand |
| sumOut | output | WIDTH | Wrap-around sum of the two operands |

## Verification
The assertions are immediate checks evaluated whenever the operands change. They assume both operands are fully driven with known values, and they are skipped while any operand bit is unknown. The stimulus respects this by driving every operand bit from the first time step onwards. It changes operands only away from clock edges, and it samples sumOut only after the combinational logic has settled.

// File: rtl/prefix_adder_pkg.sv
package prefix_adder_pkg;

  // Generate/propagate pair for a single bit or a group of bits.
  typedef struct packed {
    logic gen;
    logic prop;
  } gpPair_t;

  // Width of the lower part when a range of n bits is split.
  function automatic int lowSpan(input int n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/pa_gp_cell.sv
module pa_gp_cell
  import prefix_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic    [WIDTH-1:0] opA,
  input  logic    [WIDTH-1:0] opB,
  output gpPair_t [WIDTH-1:0] bitGp
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bitGp[i].gen  = opA[i] & opB[i];
    assign bitGp[i].prop = opA[i] ^ opB[i];
  end

endmodule

// File: rtl/pa_merge_cell.sv
module pa_merge_cell
  import prefix_adder_pkg::*;
(
  input  gpPair_t lowGrp,
  input  gpPair_t highGrp,
  output gpPair_t mergedGrp
);

  assign mergedGrp.gen  = highGrp.gen | (lowGrp.gen & highGrp.prop);
  assign mergedGrp.prop = lowGrp.prop & highGrp.prop;

endmodule

// File: rtl/pa_eval_cell.sv
module pa_eval_cell
  import prefix_adder_pkg::*;
(
  input  gpPair_t grp,
  input  logic    carryIn,
  output logic    carryOut
);

  assign carryOut = grp.gen | (grp.prop & carryIn);

endmodule

// File: rtl/pa_carry_tree.sv
module pa_carry_tree
  import prefix_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  gpPair_t [WIDTH-1:0] bitGp,
  input  logic                carryIn,
  output logic    [WIDTH-1:0] carryVec,
  output gpPair_t             groupGp
);

  localparam int LOW_W  = (WIDTH > 1) ? lowSpan(WIDTH) : 1;
  localparam int HIGH_W = (WIDTH > 1) ? (WIDTH - LOW_W) : 1;

  if (WIDTH == 1) begin : g_leaf
    // A single position takes the carry handed to its range.
    assign carryVec[0] = carryIn;
    assign groupGp     = bitGp[0];
  end else begin : g_split
    gpPair_t             lowGp;
    gpPair_t             highGp;
    logic    [LOW_W-1:0] lowCarry;
    logic    [HIGH_W-1:0] highCarry;
    logic                midCarry;

    pa_carry_tree #(.WIDTH(LOW_W)) u_low (
      .bitGp   (bitGp[LOW_W-1:0]),
      .carryIn (carryIn),
      .carryVec(lowCarry),
      .groupGp (lowGp)
    );

    // Carry into the upper half comes from the lower half's group.
    pa_eval_cell u_eval (
      .grp     (lowGp),
      .carryIn (carryIn),
      .carryOut(midCarry)
    );

    pa_carry_tree #(.WIDTH(HIGH_W)) u_high (
      .bitGp   (bitGp[WIDTH-1:LOW_W]),
      .carryIn (midCarry),
      .carryVec(highCarry),
      .groupGp (highGp)
    );

    pa_merge_cell u_merge (
      .lowGrp   (lowGp),
      .highGrp  (highGp),
      .mergedGrp(groupGp)
    );

    assign carryVec = {highCarry, lowCarry};
  end

endmodule

// File: rtl/pa_sum_bank.sv
module pa_sum_bank #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] carryVec,
  output logic [WIDTH-1:0] sumVec
);

  // Sum output of a full adder per bit; its carry output is not needed
  // because the tree already supplies every carry.
  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sumVec[i] = opA[i] ^ opB[i] ^ carryVec[i];
  end

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder
  import prefix_adder_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] addendA,
  input  logic [WIDTH-1:0] addendB,
  output logic [WIDTH-1:0] sumOut
);

  gpPair_t [WIDTH-1:0] bitGp;
  logic    [WIDTH-1:0] carryVec;
  gpPair_t             rootGp;

  pa_gp_cell #(.WIDTH(WIDTH)) u_gp (
    .opA  (addendA),
    .opB  (addendB),
    .bitGp(bitGp)
  );

  // R3: the carry entering bit 0 is tied low.
  pa_carry_tree #(.WIDTH(WIDTH)) u_tree (
    .bitGp   (bitGp),
    .carryIn (1'b0),
    .carryVec(carryVec),
    .groupGp (rootGp)
  );

  pa_sum_bank #(.WIDTH(WIDTH)) u_sum (
    .opA     (addendA),
    .opB     (addendB),
    .carryVec(carryVec),
    .sumVec  (sumOut)
  );

endmodule

// File: rtl/pa_checker.sv
module pa_checker
  import prefix_adder_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic    [WIDTH-1:0] addendA,
  input logic    [WIDTH-1:0] addendB,
  input logic    [WIDTH-1:0] sumOut,
  input logic    [WIDTH-1:0] carryVec,
  input gpPair_t             rootGp
);

  logic [WIDTH:0] refWide;
  logic           inputsKnown;

  assign refWide     = {1'b0, addendA} + {1'b0, addendB};
  assign inputsKnown = !$isunknown({addendA, addendB});

  always_comb begin
    if (inputsKnown) begin
      a_r1_sum_matches: assert (sumOut == refWide[WIDTH-1:0])
        else $error("R1 sum mismatch");
      a_r3_no_low_carry: assert (carryVec[0] == 1'b0)
        else $error("R3 carry into bit 0");
      a_r2_dropped_carry: assert (rootGp.gen == refWide[WIDTH])
        else $error("R2 root generate disagrees with carry out");
      if (addendB == '0) begin
        a_r7_zero_identity: assert (sumOut == addendA)
          else $error("R7 zero operand changed result");
      end
    end
  end

endmodule

bind prefix_adder pa_checker #(.WIDTH(WIDTH)) u_check (
  .addendA (addendA),
  .addendB (addendB),
  .sumOut  (sumOut),
  .carryVec(carryVec),
  .rootGp  (rootGp)
);

// File: tb/tb_prefix_adder.sv
module tb_prefix_adder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] opA32 = '0, opB32 = '0;
  wire  [31:0] sum32;
  logic [15:0] opA16 = '0, opB16 = '0;
  wire  [15:0] sum16;
  logic [4:0]  opA5 = '0, opB5 = '0;
  wire  [4:0]  sum5;
  logic [2:0]  opA3 = '0, opB3 = '0;
  wire  [2:0]  sum3;
  logic        opA1 = 1'b0, opB1 = 1'b0;
  wire         sum1;

  prefix_adder #(.WIDTH(32)) dut   (.addendA(opA32), .addendB(opB32), .sumOut(sum32));
  prefix_adder #(.WIDTH(16)) dutW16(.addendA(opA16), .addendB(opB16), .sumOut(sum16));
  prefix_adder #(.WIDTH(5))  dutW5 (.addendA(opA5),  .addendB(opB5),  .sumOut(sum5));
  prefix_adder #(.WIDTH(3))  dutW3 (.addendA(opA3),  .addendB(opB3),  .sumOut(sum3));
  prefix_adder #(.WIDTH(1))  dutW1 (.addendA(opA1),  .addendB(opB1),  .sumOut(sum1));

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  // {operand A, operand B, expected sum} at WIDTH 32
  localparam logic [95:0] VEC [8] = '{
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE},
    {32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},
    {32'h0000_FFFF, 32'h0000_0001, 32'h0001_0000},
    {32'h1234_5678, 32'h0000_0000, 32'h1234_5678},
    {32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF},
    {32'h89AB_CDEF, 32'h1234_5678, 32'h9BE0_2467}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    // Reset phase: all operands zero, sum must be zero (R3).
    repeat (3) @(negedge clk);
    #1;
    check("R3 reset zero", sum32, 32'h0);
    rstN = 1'b1;

    // Table walk, both operand orders (R1, R2, R3, R4, R6, R7).
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      opA32 = VEC[k][95:64];
      opB32 = VEC[k][63:32];
      #1;
      check($sformatf("R1 table %0d", k), sum32, VEC[k][31:0]);
      @(negedge clk);
      opA32 = VEC[k][63:32];
      opB32 = VEC[k][95:64];
      #1;
      check($sformatf("R6 swapped %0d", k), sum32, VEC[k][31:0]);
    end

    // R8: output follows input mid-cycle, with no clock edge in between.
    @(posedge clk);
    #1;
    opA32 = 32'h0000_00FF;
    opB32 = 32'h0000_0001;
    #0.5;
    check("R8 same step", sum32, 32'h0000_0100);

    // R2 and R4 at WIDTH 16.
    @(negedge clk);
    opA16 = 16'hFFFF; opB16 = 16'h0001;
    #1;
    check("R2 wrap w16", {16'h0, sum16}, 32'h0);
    @(negedge clk);
    opA16 = 16'h00FF; opB16 = 16'h0001;
    #1;
    check("R4 split w16", {16'h0, sum16}, 32'h0000_0100);

    // R3: bit 0 is the XOR of the operand LSBs.
    @(negedge clk);
    opA32 = 32'h0000_0001; opB32 = 32'h0000_0001;
    #1;
    check("R3 lsb", {31'h0, sum32[0]}, 32'h0);

    // R5: exhaustive at widths 1, 3 and 5.
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        @(negedge clk);
        opA5 = 5'(i); opB5 = 5'(j);
        opA3 = 3'(i); opB3 = 3'(j);
        opA1 = i[0];  opB1 = j[0];
        #1;
        check("R5 w5", {27'h0, sum5}, 32'((i + j) % 32));
        if (i < 8 && j < 8)
          check("R5 w3", {29'h0, sum3}, 32'((i + j) % 8));
        if (i < 2 && j < 2)
          check("R5 w1", {31'h0, sum1}, 32'((i + j) % 2));
      end
    end

    // R1: random vectors at widths 16 and 32.
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      opA32 = $urandom; opB32 = $urandom;
      opA16 = 16'($urandom); opB16 = 16'($urandom);
      #1;
      check("R1 random w32", sum32, 32'(64'(opA32) + 64'(opB32)));
      check("R1 random w16", {16'h0, sum16}, {16'h0, 16'(32'(opA16) + 32'(opB16))});
    end

    // R7: zero operand on either side.
    @(negedge clk);
    opA32 = 32'h0; opB32 = 32'hDEAD_BEEF;
    #1;
    check("R7 zero a", sum32, 32'hDEAD_BEEF);

    done = 1'b1;
    finishRun();
  end

endmodule